// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block sequences instruction fetch addresses for a small 8-bit microcontroller core. It keeps a 10-bit program counter and a two-deep hardware return stack. Each cycle the core's decoder raises at most one of several strobes: step, jump, subroutine call, subroutine return or a data write to the low address byte. The block turns that strobe into the next fetch address. Jump targets take their low bits from the instruction-word field and their top bit from a page-select bit that the status register supplies.

Calls and computed jumps, meaning writes to the low byte, always clear address bit 8. They can only reach the lower half of each 512-word page. The return stack cannot be reached through any data path. When it overflows it drops its oldest entry. When it underflows it keeps handing back the deepest stored entry. Both outputs come straight from the program counter register, so they change one clock edge after a strobe is sampled.

Top module: `paged_pc_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter loads 0x3FF, so `pcl_o` reads 0xFF after that edge.
- R2: With `step_i` as the winning strobe, the counter advances by one modulo 1024, so 0x3FF is followed by 0x000.
- R3: A jump loads bit 9 from `page_i` and bits 8..0 from `field_i[8:0]`.
- R4: A call loads bit 9 from `page_i`, clears bit 8, and loads bits 7..0 from `field_i[7:0]`. It also pushes the current address plus one onto the stack.
- R5: A low-byte write loads bit 9 from `page_i`, clears bit 8, and loads bits 7..0 from `wdata_i`.
- R6: A return loads the counter from stack level 1, moves level 2 into level 1, and leaves level 2 unchanged.
- R7: After three or more calls in a row, only the two most recent return addresses remain. Any older one is lost.
- R8: After the stack is drained, every further return yields the value last held in level 2.
- R9: When several strobes are high together, the winner is chosen in this order: return, call, jump, low-byte write, step.
- R10: With no strobe high, the counter keeps its value.
- R11: `pcl_o` always equals bits 7..0 of `fetch_addr_o`.
- R12: Reset clears both stack levels to 0x000, so a return straight after reset goes to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Sequential advance strobe |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Subroutine call strobe |
| ret_i | input | 1 | Subroutine return strobe |
| lowwr_i | input | 1 | Data write to the low address byte |
| field_i | input | 9 | Address field of the instruction word |
| page_i | input | 1 | Page-select bit from the status register |
| wdata_i | input | 8 | Value written to the low address byte |
| fetch_addr_o | output | 10 | Current fetch address |
| pcl_o | output | 8 | Low byte of the fetch address |

## Verification
The bench builds the block with its default parameters. These are a 10-bit counter, an 8-bit low byte and a two-level stack, which give exactly the page layout and stack depth that the requirements describe. A stack this shallow puts overflow within three calls and underflow within three returns, so both are exercised. A counter this small lets a single step wrap from 0x3FF back to zero straight after reset.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_STEP = 3'd1,
    OP_LOWW = 3'd2,
    OP_JUMP = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5
  } pc_op_e;
endpackage

// File: rtl/pgseq_select.sv
module pgseq_select
  import pgseq_pkg::*;
(
  input  logic   step_i,
  input  logic   jump_i,
  input  logic   call_i,
  input  logic   ret_i,
  input  logic   lowwr_i,
  output pc_op_e op_o
);
  // Fixed priority; return wins over everything (R9)
  always_comb begin
    if (ret_i)        op_o = OP_RET;
    else if (call_i)  op_o = OP_CALL;
    else if (jump_i)  op_o = OP_JUMP;
    else if (lowwr_i) op_o = OP_LOWW;
    else if (step_i)  op_o = OP_STEP;
    else              op_o = OP_HOLD;
  end
endmodule

// File: rtl/pgseq_target.sv
module pgseq_target
  import pgseq_pkg::*;
#(
  parameter int PC_W  = 10,
  parameter int LOW_W = 8
) (
  input  pc_op_e            op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              page_i,
  input  logic [PC_W-2:0]   field_i,
  input  logic [LOW_W-1:0]  wdata_i,
  input  logic [PC_W-1:0]   stack_top_i,
  output logic [PC_W-1:0]   next_o,
  output logic [PC_W-1:0]   ret_addr_o
);
  localparam int PAGE_BIT = PC_W - 1;

  logic [PC_W-1:0] near_call;
  logic [PC_W-1:0] near_low;
  logic [PC_W-1:0] far_jump;

  // Calls and low-byte writes clear every bit between the low byte and the page bit
  always_comb begin
    near_call = '0;
    near_call[LOW_W-1:0] = field_i[LOW_W-1:0];
    near_call[PAGE_BIT]  = page_i;
    near_low = '0;
    near_low[LOW_W-1:0]  = wdata_i;
    near_low[PAGE_BIT]   = page_i;
    far_jump = {page_i, field_i};
  end

  assign ret_addr_o = pc_i + PC_W'(1);

  always_comb begin
    unique case (op_i)
      OP_RET:  next_o = stack_top_i;
      OP_CALL: next_o = near_call;
      OP_JUMP: next_o = far_jump;
      OP_LOWW: next_o = near_low;
      OP_STEP: next_o = pc_i + PC_W'(1);
      default: next_o = pc_i;
    endcase
  end
endmodule

// File: rtl/pgseq_stack.sv
module pgseq_stack #(
  parameter int W     = 10,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_val_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0] lvl [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [W-1:0] from_above;
    logic [W-1:0] from_below;
    if (i == 0) begin : g_head
      assign from_above = push_val_i;
    end else begin : g_body
      assign from_above = lvl[i-1];
    end
    if (i == DEPTH - 1) begin : g_tail
      assign from_below = lvl[i];   // deepest level repeats on underflow (R8)
    end else begin : g_mid
      assign from_below = lvl[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)         lvl[i] <= '0;          // R12
      else if (push_i) lvl[i] <= from_above;  // oldest falls off (R7)
      else if (pop_i)  lvl[i] <= from_below;
    end
  end

  assign top_o = lvl[0];

  p_push_top_r4: assert property (@(posedge clk) disable iff (rst)
    push_i |=> lvl[0] == $past(push_val_i));
  p_pop_deep_keep_r8: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i) |=> lvl[DEPTH-1] == $past(lvl[DEPTH-1]));
  p_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(push_i && pop_i));
endmodule

// File: rtl/paged_pc_seq.sv
module paged_pc_seq
  import pgseq_pkg::*;
#(
  parameter int PC_W     = 10,
  parameter int LOW_W    = 8,
  parameter int STACK_D  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic             jump_i,
  input  logic             call_i,
  input  logic             ret_i,
  input  logic             lowwr_i,
  input  logic [PC_W-2:0]  field_i,
  input  logic             page_i,
  input  logic [LOW_W-1:0] wdata_i,
  output logic [PC_W-1:0]  fetch_addr_o,
  output logic [LOW_W-1:0] pcl_o
);
  pc_op_e          op;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_next;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] stack_top;

  pgseq_select u_sel (
    .step_i (step_i),
    .jump_i (jump_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .lowwr_i(lowwr_i),
    .op_o   (op)
  );

  pgseq_target #(.PC_W(PC_W), .LOW_W(LOW_W)) u_tgt (
    .op_i       (op),
    .pc_i       (pc_q),
    .page_i     (page_i),
    .field_i    (field_i),
    .wdata_i    (wdata_i),
    .stack_top_i(stack_top),
    .next_o     (pc_next),
    .ret_addr_o (ret_addr)
  );

  pgseq_stack #(.W(PC_W), .DEPTH(STACK_D)) u_stk (
    .clk       (clk),
    .rst       (rst),
    .push_i    (op == OP_CALL),
    .pop_i     (op == OP_RET),
    .push_val_i(ret_addr),
    .top_o     (stack_top)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '1;   // R1
    else     pc_q <= pc_next;
  end

  assign fetch_addr_o = pc_q;
  assign pcl_o        = pc_q[LOW_W-1:0];   // R11

  p_reset_val_r1: assert property (@(posedge clk)
    rst |=> fetch_addr_o == '1);
  p_step_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STEP) |=> fetch_addr_o == $past(fetch_addr_o) + PC_W'(1));
  p_jump_load_r3: assert property (@(posedge clk) disable iff (rst)
    (jump_i && !call_i && !ret_i) |=> fetch_addr_o == {$past(page_i), $past(field_i)});
  p_ret_load_r6: assert property (@(posedge clk) disable iff (rst)
    ret_i |=> fetch_addr_o == $past(stack_top));
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (op == OP_HOLD) |=> $stable(fetch_addr_o));
endmodule

// File: tb/paged_pc_seq_tb.sv
module paged_pc_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       step_i = 0, jump_i = 0, call_i = 0, ret_i = 0, lowwr_i = 0;
  logic [8:0] field_i = '0;
  logic       page_i = 0;
  logic [7:0] wdata_i = '0;
  logic [9:0] fetch_addr_o;
  logic [7:0] pcl_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic [9:0] pc; string tag; } exp_t;
  exp_t q[$];

  // bench reference state
  logic [9:0] m_pc = 10'h3FF, m_s1 = '0, m_s2 = '0;

  always #10 clk = ~clk;   // 50 MHz

  paged_pc_seq u_dut (
    .clk(clk), .rst(rst), .step_i(step_i), .jump_i(jump_i), .call_i(call_i),
    .ret_i(ret_i), .lowwr_i(lowwr_i), .field_i(field_i), .page_i(page_i),
    .wdata_i(wdata_i), .fetch_addr_o(fetch_addr_o), .pcl_o(pcl_o)
  );

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic drive(input logic r, input logic s, input logic j, input logic c,
                       input logic rt, input logic lw, input logic [8:0] f,
                       input logic pg, input logic [7:0] d, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; step_i = s; jump_i = j; call_i = c; ret_i = rt; lowwr_i = lw;
    field_i = f; page_i = pg; wdata_i = d;
    if (r) begin
      m_pc = 10'h3FF; m_s1 = '0; m_s2 = '0;
    end else if (rt) begin
      m_pc = m_s1; m_s1 = m_s2;
    end else if (c) begin
      m_s2 = m_s1; m_s1 = m_pc + 10'd1;
      m_pc = {pg, 1'b0, f[7:0]};
    end else if (j) begin
      m_pc = {pg, f};
    end else if (lw) begin
      m_pc = {pg, 1'b0, d};
    end else if (s) begin
      m_pc = m_pc + 10'd1;
    end
    e.pc = m_pc; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares after each rising edge, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (fetch_addr_o !== e.pc) begin
          n_fail++;
          $display("FAIL %s addr actual=%h expected=%h", e.tag, fetch_addr_o, e.pc);
        end
        n_chk++;
        if (pcl_o !== e.pc[7:0]) begin
          n_fail++;
          $display("FAIL R11 (%s) pcl actual=%h expected=%h", e.tag, pcl_o, e.pc[7:0]);
        end
      end
    end
  end

  initial begin
    fork
      begin
        drive(1,0,0,0,0,0,9'h000,0,8'h00,"R1");
        drive(1,1,1,1,1,1,9'h1FF,1,8'hAA,"R1");
        drive(0,0,0,0,0,0,9'h123,1,8'h55,"R10");
        drive(0,1,0,0,0,0,9'h000,0,8'h00,"R2");        // 3FF -> 000
        drive(0,1,0,0,0,0,9'h000,0,8'h00,"R2");
        drive(0,0,1,0,0,0,9'h1A5,1,8'h00,"R3");        // 3A5
        drive(0,0,1,0,0,0,9'h0F0,0,8'h00,"R3");        // 0F0
        drive(0,0,0,1,0,0,9'h142,0,8'h00,"R4");        // 042, push 0F1
        drive(0,0,0,0,0,1,9'h000,1,8'h77,"R5");        // 277
        drive(0,0,0,1,0,0,9'h010,1,8'h00,"R4");        // 210, push 278
        drive(0,0,0,1,0,0,9'h020,0,8'h00,"R7");        // 020, push 211, 0F1 lost
        drive(0,0,0,0,1,0,9'h000,0,8'h00,"R6");        // 211
        drive(0,0,0,0,1,0,9'h000,0,8'h00,"R7");        // 278
        drive(0,0,0,0,1,0,9'h000,0,8'h00,"R8");        // 278 again
        drive(0,0,0,0,1,0,9'h000,0,8'h00,"R8");
        drive(0,0,0,0,0,0,9'h000,0,8'h00,"R10");
        drive(0,1,1,1,1,1,9'h1C3,1,8'h99,"R9");        // return wins
        drive(0,1,1,1,0,1,9'h1C3,1,8'h99,"R9");        // call wins
        drive(0,1,1,0,0,1,9'h1C3,0,8'h99,"R9");        // jump wins
        drive(0,1,0,0,0,1,9'h1C3,1,8'h99,"R9");        // low write wins
        drive(0,0,0,0,0,1,9'h000,0,8'hFF,"R5");
        drive(0,1,0,0,0,0,9'h000,0,8'h00,"R2");
        drive(1,0,0,0,0,0,9'h000,0,8'h00,"R1");
        drive(0,0,0,0,1,0,9'h000,0,8'h00,"R12");       // empty stack -> 000
        drive(0,0,0,0,1,0,9'h000,0,8'h00,"R12");
        drive(0,0,0,0,0,0,9'h000,0,8'h00,"R10");
        repeat (3) @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule